// File: doc/BRIEF.md
# Battery Pack Current-Fault Supervisor

This block is the digital timing and latching core behind a battery pack's current-fault protection. Three already-digitised comparator results arrive from the analog front end: discharge overcurrent, charge overcurrent and short circuit. Each one is qualified by a delay counter clocked from a 10 µs tick input. When a delay runs out, the block latches a sticky fault flag and drops the matching FET enable. A short circuit or a discharge overcurrent opens the discharge FET. A charge overcurrent opens the charge FET.

A host controller programs the block through a simple parallel write port, which replaces a serial link. The write port sets the FET enables, the delay selections and the threshold codes sent to the comparators. The host also clears flags through this port by writing ones. The FETs never turn back on by themselves; the host has to command them on again after clearing the fault. A load-fail flag records that a discharge-side fault opened the path. When load monitoring is enabled, this flag drops once the load-present input falls.

Register map: address 0 is control, address 1 is delay selection, address 2 is threshold selection and address 3 is flag clear. Field positions are given in the requirements.

Top module: `ocp_supervisor`

## Requirements
- R1: After reset both FET outputs are off, all four flags are clear, and all three threshold codes and all delay fields read as zero.
- R2: Delay register (address 1) bits [1:0] give the discharge delay code c, and bit 4 selects the fast range. With `dsg_oc_trip` high on every tick, `flag_doc` sets and `dsg_fet_on` falls after 16000·2^c ticks in the slow range or 250·2^c ticks in the fast range (160 ms / 2.5 ms times 2^c at 10 µs).
- R3: Delay register bits [3:2] give the charge delay code, and bit 5 selects its fast range. The mapping is the same as in R2. On expiry `flag_coc` sets and `chg_fet_on` falls, while the discharge FET and load-fail are unaffected.
- R4: A short circuit held for 19 ticks sets `flag_sc`, or for 1000 ticks when delay register bit 6 (long) is set. It turns off only the discharge FET.
- R5: A comparator input that goes low before its delay expires restarts that delay from zero.
- R6: Control register (address 0) bit 0 enables the charge FET and bit 1 enables the discharge FET. A FET turns on only by such a host write. A fault clears its enable bit. A write of 1 is ignored while the matching fault flag is set. Clearing a flag never turns a FET back on.
- R7: The host can turn either FET off at any time by writing 0 to its control bit.
- R8: Clear register (address 3) bits 0, 1 and 2 clear the short-circuit, discharge and charge flags when written with 1. Flags are sticky otherwise. A fault expiring in the same cycle as its clear write leaves the flag set.
- R9: `load_fail` sets on any discharge overcurrent or short-circuit fault. It clears when control bit 2 (load monitor) is set and `load_present` is low. While monitoring is off it holds.
- R10: Threshold register (address 2) bits [1:0], [3:2] and [5:4] appear on `thr_dsg_oc`, `thr_chg_oc` and `thr_sc` after the write.
- R11: Delay counters advance only in cycles where `tick` is high. A comparator held high with no ticks never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 10 µs, the delay time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| dsg_oc_trip | input | 1 | Discharge overcurrent comparator result |
| chg_oc_trip | input | 1 | Charge overcurrent comparator result |
| short_trip | input | 1 | Short-circuit comparator result |
| load_present | input | 1 | High while a load is still sensed on the pack output |
| chg_fet_on | output | 1 | Charge FET enable to the gate driver |
| dsg_fet_on | output | 1 | Discharge FET enable to the gate driver |
| flag_sc | output | 1 | Sticky short-circuit fault flag |
| flag_doc | output | 1 | Sticky discharge overcurrent flag |
| flag_coc | output | 1 | Sticky charge overcurrent flag |
| load_fail | output | 1 | Load-fail flag |
| thr_dsg_oc | output | 2 | Discharge overcurrent threshold code to the comparator |
| thr_chg_oc | output | 2 | Charge overcurrent threshold code to the comparator |
| thr_sc | output | 2 | Short-circuit threshold code to the comparator |

## Verification
Two events can land on the same clock edge: a short-circuit delay expiring and the host's write-one clear of that same flag. The bench holds `short_trip` high for 18 ticks and then raises a clear write together with the 19th tick. The flag must read set afterwards, because a fresh fault must never be lost to a stale clear. A second, separate clear write must then drop the flag. The same edge also checks that the discharge FET opened and load-fail rose.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Time base: one tick per 10 us.
  parameter int unsigned OC_BASE_TICKS  = 16000; // slow range, code 0 (160 ms)
  parameter int unsigned RANGE_SHIFT    = 6;     // fast range divides by 64
  parameter int unsigned SC_SHORT_TICKS = 19;    // about 190 us
  parameter int unsigned SC_LONG_TICKS  = 1000;  // about 10 ms
  parameter int unsigned CODE_STEPS     = 4;     // 2-bit delay code

  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DATA_W = 8;

  localparam int unsigned CNT_W = $clog2(OC_BASE_TICKS * (1 << (CODE_STEPS - 1)) + 1);

  // Fault sources, used as indices of the timer array.
  localparam int unsigned NSRC    = 3;
  localparam int unsigned IDX_DOC = 0;
  localparam int unsigned IDX_COC = 1;
  localparam int unsigned IDX_SC  = 2;

  // Register addresses.
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DELAY = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(3);

  // Overcurrent delay in ticks: base doubled per code step, range bit divides by 64.
  function automatic logic [CNT_W-1:0] oc_delay_ticks(input logic [1:0] code,
                                                      input logic fast);
    int unsigned base;
    base = fast ? (OC_BASE_TICKS >> RANGE_SHIFT) : OC_BASE_TICKS;
    return CNT_W'(base << code);
  endfunction

  // Short-circuit delay in ticks.
  function automatic logic [CNT_W-1:0] sc_delay_ticks(input logic long_sel);
    return long_sel ? CNT_W'(SC_LONG_TICKS) : CNT_W'(SC_SHORT_TICKS);
  endfunction

endpackage

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer
  import ocp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trip_in,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_plus;
  logic             reach;

  assign cnt_plus = {1'b0, cnt} + (CNT_W + 1)'(1);
  assign reach    = (cnt_plus >= {1'b0, limit});
  assign fire     = trip_in && tick && reach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!trip_in) begin
      cnt <= '0;                      // comparator released: restart
    end else if (tick) begin
      cnt <= fire ? '0 : cnt_plus[CNT_W-1:0];
    end
  end

  // R5: a released comparator leaves the counter at zero
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_in |=> (cnt == '0));

  // R11: without a tick the count does not move
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_in && !tick) |=> $stable(cnt));

  // R11: each qualifying tick adds exactly one
  p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_in && tick && !fire) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/ocp_regs.sv
module ocp_regs
  import ocp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NSRC-1:0]   fire,
  input  logic              load_present,
  output logic              chg_fet_on,
  output logic              dsg_fet_on,
  output logic              flag_sc,
  output logic              flag_doc,
  output logic              flag_coc,
  output logic              load_fail,
  output logic [1:0]        dsg_code,
  output logic [1:0]        chg_code,
  output logic              dsg_fast,
  output logic              chg_fast,
  output logic              sc_long,
  output logic [1:0]        thr_dsg_oc,
  output logic [1:0]        thr_chg_oc,
  output logic [1:0]        thr_sc
);

  // Decoded write events
  logic wr_ctrl, wr_delay, wr_thr, wr_clr;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_delay = wr_en && (wr_addr == A_DELAY);
  assign wr_thr   = wr_en && (wr_addr == A_THR);
  assign wr_clr   = wr_en && (wr_addr == A_CLR);

  // Fault events seen by each FET path
  logic dsg_fault_evt, chg_fault_evt;
  assign dsg_fault_evt = fire[IDX_DOC] || fire[IDX_SC];
  assign chg_fault_evt = fire[IDX_COC];

  // Write-one-clear requests
  logic clr_sc, clr_doc, clr_coc;
  assign clr_sc  = wr_clr && wr_data[0];
  assign clr_doc = wr_clr && wr_data[1];
  assign clr_coc = wr_clr && wr_data[2];

  logic dsg_blocked, chg_blocked;
  assign dsg_blocked = flag_doc || flag_sc;
  assign chg_blocked = flag_coc;

  logic chg_en_q, dsg_en_q, mon_en_q;

  logic unused_bits;
  assign unused_bits = ^wr_data[DATA_W-1:7];

  // Control: enables may only be raised by the host, faults take priority
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_en_q <= 1'b0;
      dsg_en_q <= 1'b0;
      mon_en_q <= 1'b0;
    end else begin
      if (chg_fault_evt)     chg_en_q <= 1'b0;
      else if (wr_ctrl)      chg_en_q <= wr_data[0] && !chg_blocked;
      if (dsg_fault_evt)     dsg_en_q <= 1'b0;
      else if (wr_ctrl)      dsg_en_q <= wr_data[1] && !dsg_blocked;
      if (wr_ctrl)           mon_en_q <= wr_data[2];
    end
  end

  // Delay and threshold selections
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsg_code   <= 2'b00;
      chg_code   <= 2'b00;
      dsg_fast   <= 1'b0;
      chg_fast   <= 1'b0;
      sc_long    <= 1'b0;
      thr_dsg_oc <= 2'b00;
      thr_chg_oc <= 2'b00;
      thr_sc     <= 2'b00;
    end else begin
      if (wr_delay) begin
        dsg_code <= wr_data[1:0];
        chg_code <= wr_data[3:2];
        dsg_fast <= wr_data[4];
        chg_fast <= wr_data[5];
        sc_long  <= wr_data[6];
      end
      if (wr_thr) begin
        thr_dsg_oc <= wr_data[1:0];
        thr_chg_oc <= wr_data[3:2];
        thr_sc     <= wr_data[5:4];
      end
    end
  end

  // Sticky flags: a new fault wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_sc   <= 1'b0;
      flag_doc  <= 1'b0;
      flag_coc  <= 1'b0;
      load_fail <= 1'b0;
    end else begin
      flag_sc  <= fire[IDX_SC]  || (flag_sc  && !clr_sc);
      flag_doc <= fire[IDX_DOC] || (flag_doc && !clr_doc);
      flag_coc <= fire[IDX_COC] || (flag_coc && !clr_coc);
      if (dsg_fault_evt)                  load_fail <= 1'b1;
      else if (mon_en_q && !load_present) load_fail <= 1'b0;
    end
  end

  assign chg_fet_on = chg_en_q && !chg_blocked;
  assign dsg_fet_on = dsg_en_q && !dsg_blocked;

  // R8: a fault always leaves its flag set, clear or not
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire[IDX_SC] |=> flag_sc);

  // R8: without a clear write the flag holds
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_doc && !clr_doc) |=> flag_doc);

  // R9: monitored, released load clears load-fail
  p_ldf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fail && mon_en_q && !load_present && !dsg_fault_evt) |=> !load_fail);

  // R9: with monitoring off load-fail holds
  p_ldf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fail && !mon_en_q) |=> load_fail);

endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
  import ocp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dsg_oc_trip,
  input  logic              chg_oc_trip,
  input  logic              short_trip,
  input  logic              load_present,
  output logic              chg_fet_on,
  output logic              dsg_fet_on,
  output logic              flag_sc,
  output logic              flag_doc,
  output logic              flag_coc,
  output logic              load_fail,
  output logic [1:0]        thr_dsg_oc,
  output logic [1:0]        thr_chg_oc,
  output logic [1:0]        thr_sc
);

  logic [1:0]       dsg_code, chg_code;
  logic             dsg_fast, chg_fast, sc_long;
  logic [NSRC-1:0]  trip_vec;
  logic [NSRC-1:0]  fire;
  logic [CNT_W-1:0] limit [NSRC];

  assign trip_vec[IDX_DOC] = dsg_oc_trip;
  assign trip_vec[IDX_COC] = chg_oc_trip;
  assign trip_vec[IDX_SC]  = short_trip;

  always_comb begin
    limit[IDX_DOC] = oc_delay_ticks(dsg_code, dsg_fast);
    limit[IDX_COC] = oc_delay_ticks(chg_code, chg_fast);
    limit[IDX_SC]  = sc_delay_ticks(sc_long);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_timer
    ocp_fault_timer u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .trip_in (trip_vec[i]),
      .limit   (limit[i]),
      .fire    (fire[i])
    );
  end

  ocp_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .fire         (fire),
    .load_present (load_present),
    .chg_fet_on   (chg_fet_on),
    .dsg_fet_on   (dsg_fet_on),
    .flag_sc      (flag_sc),
    .flag_doc     (flag_doc),
    .flag_coc     (flag_coc),
    .load_fail    (load_fail),
    .dsg_code     (dsg_code),
    .chg_code     (chg_code),
    .dsg_fast     (dsg_fast),
    .chg_fast     (chg_fast),
    .sc_long      (sc_long),
    .thr_dsg_oc   (thr_dsg_oc),
    .thr_chg_oc   (thr_chg_oc),
    .thr_sc       (thr_sc)
  );

  // R4: a short circuit opens the discharge path
  p_sc_opens_dsg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire[IDX_SC] |=> !dsg_fet_on);

  // R2: discharge overcurrent opens the discharge path
  p_doc_opens_dsg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire[IDX_DOC] |=> !dsg_fet_on);

  // R3: charge overcurrent opens the charge path
  p_coc_opens_chg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire[IDX_COC] |=> !chg_fet_on);

  // R6: the discharge FET turns on only after a host enable write
  p_no_auto_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsg_fet_on) |-> $past(wr_en && (wr_addr == A_CTRL) && wr_data[1]));

  // R6: the charge FET turns on only after a host enable write
  p_no_auto_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_fet_on) |-> $past(wr_en && (wr_addr == A_CTRL) && wr_data[0]));

endmodule

// File: tb/ocp_supervisor_test.sv
module ocp_supervisor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       dsg_oc_trip = 1'b0, chg_oc_trip = 1'b0, short_trip = 1'b0;
  logic       load_present = 1'b1;
  logic       chg_fet_on, dsg_fet_on, flag_sc, flag_doc, flag_coc, load_fail;
  logic [1:0] thr_dsg_oc, thr_chg_oc, thr_sc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ocp_supervisor uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dsg_oc_trip(dsg_oc_trip), .chg_oc_trip(chg_oc_trip), .short_trip(short_trip),
    .load_present(load_present),
    .chg_fet_on(chg_fet_on), .dsg_fet_on(dsg_fet_on),
    .flag_sc(flag_sc), .flag_doc(flag_doc), .flag_coc(flag_coc), .load_fail(load_fail),
    .thr_dsg_oc(thr_dsg_oc), .thr_chg_oc(thr_chg_oc), .thr_sc(thr_sc)
  );

  // Observed vector: [0] chg, [1] dsg, [2] doc, [3] coc, [4] sc, [5] load_fail,
  // [7:6] thr_dsg_oc, [9:8] thr_chg_oc, [11:10] thr_sc
  logic [11:0] obs;
  assign obs = {thr_sc, thr_chg_oc, thr_dsg_oc, load_fail, flag_sc, flag_coc,
                flag_doc, dsg_fet_on, chg_fet_on};

  typedef struct {
    string       tag;
    logic [11:0] exp;
    logic [11:0] mask;
  } sb_item_t;

  sb_item_t sb_q[$];

  // Monitor: compares every pending expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        failures++;
        $display("FAIL %s: actual %h expected %h (mask %h) at %0t",
                 it.tag, obs & it.mask, it.exp & it.mask, it.mask, $time);
      end
    end
  end

  // Driver helpers: always return just after a rising edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_obs(input string tag, input logic [11:0] e, input logic [11:0] m);
    sb_item_t it;
    it.tag = tag; it.exp = e; it.mask = m;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  // Delay model written from the time specification
  function automatic int oc_ticks(input int code, input bit fast);
    real ms;
    ms = (fast ? 2.5 : 160.0) * real'(1 << code);
    return $rtoi(ms * 100.0 + 0.5); // 10 us per tick
  endfunction

  function automatic int sc_ticks(input bit long_sel);
    return long_sel ? 1000 : 19;
  endfunction

  // Bring the block back to both FETs on, flags and load-fail clear
  task automatic recover(input string tag);
    dsg_oc_trip = 1'b0; chg_oc_trip = 1'b0; short_trip = 1'b0;
    wr(2'd3, 8'h07);
    wr(2'd0, 8'h07);
    load_present = 1'b0;
    step(1);
    load_present = 1'b1;
    expect_obs(tag, 12'h003, 12'h03F);
    step(1);
  endtask

  // Hold a trip for n ticks; flag at bit fb must be clear at n-1, set at n
  task automatic trip_window(input string tag, input int n, input int fb);
    step(n - 1);
    expect_obs({tag, " early"}, 12'h000, 12'(1 << fb));
    step(1);
    expect_obs({tag, " expiry"}, 12'(1 << fb), 12'(1 << fb));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_obs("R1 reset state", 12'h000, 12'hFFF);
    step(1);
    rst_n = 1'b1;
    step(1);
    expect_obs("R1 after reset", 12'h000, 12'hFFF);

    // R10 thresholds
    wr(2'd2, 8'h39);
    expect_obs("R10 threshold codes", 12'hE40, 12'hFC0);

    // R6 host turns FETs on, load monitor on
    wr(2'd0, 8'h07);
    expect_obs("R6 host enable", 12'h003, 12'h03F);

    // R2 fast range, code 0
    wr(2'd1, 8'h10);
    dsg_oc_trip = 1'b1;
    trip_window("R2 fast c0", oc_ticks(0, 1'b1), 2);
    expect_obs("R2 R9 doc state", 12'h025, 12'h03F);

    // R6 enable ignored while flag set, no auto-on after clear
    dsg_oc_trip = 1'b0;
    wr(2'd0, 8'h07);
    expect_obs("R6 enable blocked", 12'h025, 12'h03F);
    wr(2'd3, 8'h02);
    expect_obs("R6 no auto-on after clear", 12'h021, 12'h03F);

    // R9 load-fail holds with monitoring off
    wr(2'd0, 8'h03);
    load_present = 1'b0;
    step(2);
    expect_obs("R9 hold when monitor off", 12'h023, 12'h03F);
    wr(2'd0, 8'h07);
    step(1);
    expect_obs("R9 clear on load release", 12'h003, 12'h03F);
    load_present = 1'b1;
    step(1);

    // R2 fast range, code 2
    wr(2'd1, 8'h12);
    dsg_oc_trip = 1'b1;
    trip_window("R2 fast c2", oc_ticks(2, 1'b1), 2);
    recover("R2 recover c2");

    // R2 slow range, code 0
    wr(2'd1, 8'h00);
    dsg_oc_trip = 1'b1;
    trip_window("R2 slow c0", oc_ticks(0, 1'b0), 2);
    recover("R2 recover slow");

    // R3 charge overcurrent, fast range code 1
    wr(2'd1, 8'h24);
    chg_oc_trip = 1'b1;
    trip_window("R3 fast c1", oc_ticks(1, 1'b1), 3);
    expect_obs("R3 only charge opens", 12'h00A, 12'h03F);
    recover("R3 recover");

    // R4 short circuit, short and long delays
    wr(2'd1, 8'h00);
    short_trip = 1'b1;
    trip_window("R4 short delay", sc_ticks(1'b0), 4);
    expect_obs("R4 only discharge opens", 12'h031, 12'h03F);
    recover("R4 recover short");
    wr(2'd1, 8'h40);
    short_trip = 1'b1;
    trip_window("R4 long delay", sc_ticks(1'b1), 4);
    recover("R4 recover long");

    // R5 restart on release
    wr(2'd1, 8'h10);
    dsg_oc_trip = 1'b1;
    step(200);
    dsg_oc_trip = 1'b0;
    step(1);
    dsg_oc_trip = 1'b1;
    trip_window("R5 restart", oc_ticks(0, 1'b1), 2);
    recover("R5 recover");

    // R11 no ticks, no progress
    tick = 1'b0;
    dsg_oc_trip = 1'b1;
    step(400);
    expect_obs("R11 no tick no trip", 12'h003, 12'h03F);
    tick = 1'b1;
    trip_window("R11 ticks resume", oc_ticks(0, 1'b1), 2);
    recover("R11 recover");

    // R8 expiry and clear in the same cycle
    wr(2'd1, 8'h00);
    short_trip = 1'b1;
    step(sc_ticks(1'b0) - 1);
    expect_obs("R8 before expiry", 12'h000, 12'h010);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
    short_trip = 1'b0;
    expect_obs("R8 set wins over clear", 12'h031, 12'h03F);
    step(3);
    expect_obs("R8 sticky", 12'h010, 12'h010);
    wr(2'd3, 8'h01);
    expect_obs("R8 write-one clear", 12'h000, 12'h010);
    recover("R8 recover");

    // R7 host switches off at any time
    wr(2'd0, 8'h05);
    expect_obs("R7 discharge off", 12'h001, 12'h003);
    wr(2'd0, 8'h04);
    expect_obs("R7 both off", 12'h000, 12'h003);

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule